// File: doc/BRIEF.md
# Peripheral Bus Address Relocation Map

This block sits between direct-memory-access masters on an 18-bit peripheral bus and a 22-bit physical memory. The upper five bits of each bus address pick one of 32 pages of 8 KB. Pages 0 through 30 each have a relocation base register. While the global map enable is high, the bus offset within the page is added to that base. While it is low, the bus address goes through unchanged, padded with zeros to 22 bits.

Page 31 never uses a base register. Its addresses always land in the topmost 8 KB of physical space, where the I/O registers live, and this holds whatever the state of the enable.

Base registers are loaded 16 bits at a time. A low-half write sets base bits 15:0, and bit 0 always stores as zero. A high-half write sets base bits 21:16. A translation request is taken in one cycle, and its result and valid flag appear on the next cycle.

Top module: `bus_relocator`

## Requirements
- R1: After reset, rsp_valid and rsp_addr are 0 and every base register holds zero. With the enable high, page p then translates to its 13-bit offset alone.
- R2: The page index is req_addr[17:13]. With map_en high, a request to a page from 0 to 30 returns (base of that page + req_addr[12:0]) modulo 2^22.
- R3: With map_en low, a request to a page from 0 to 30 returns req_addr with zeros above bit 17.
- R4: A request to page 31 returns req_addr OR 22'h3FE000, for either value of map_en.
- R5: A write with wr_hi=0 loads base bits 15:1 from wr_data[15:1] and makes base bit 0 zero. Because of this, rsp_addr[0] always equals req_addr[0]. The high half of the base is left as it was.
- R6: A write with wr_hi=1 loads base bits 21:16 from wr_data[5:0]. The low half of the base is left as it was.
- R7: A write to index 31 changes no base register.
- R8: rsp_valid is req_valid delayed by one clock. rsp_addr is updated one clock after each accepted request and keeps its value in cycles with no request.
- R9: A request made in the same cycle as a write to its page uses the base as it was before that write. The next request uses the new base.
- R10: map_en is sampled in the same cycle as the request it applies to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_en | input | 1 | Global relocation enable |
| wr_en | input | 1 | Base register write strobe |
| wr_idx | input | 5 | Index of the base register to write |
| wr_hi | input | 1 | 1 selects the high half (bits 21:16), 0 selects the low half |
| wr_data | input | 16 | Write data |
| req_valid | input | 1 | Translation request valid |
| req_addr | input | 18 | Bus address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_addr | output | 22 | Translated physical address |

## Verification
A corrupted base register appears only on the next request to its own page. It shows up exactly one cycle after that request, as a wrong rsp_addr. Every other page keeps translating correctly, so the bench touches each programmed page both in range and across the 2^22 wrap. A wrong page-select or enable path shows at once on the following response, either as a missing I/O-region prefix or as a relocated address where a pass-through was expected. A stale or corrupted output register shows in the idle cycles as a change in rsp_addr while no request is present.

// File: rtl/bus_relocator.sv
module bus_relocator #(
  parameter int BUS_AW  = 18,
  parameter int PHYS_AW = 22,
  parameter int PAGE_AW = 13,
  parameter int HALF_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               map_en,
  input  logic               wr_en,
  input  logic [BUS_AW-PAGE_AW-1:0] wr_idx,
  input  logic               wr_hi,
  input  logic [HALF_W-1:0]  wr_data,
  input  logic               req_valid,
  input  logic [BUS_AW-1:0]  req_addr,
  output logic               rsp_valid,
  output logic [PHYS_AW-1:0] rsp_addr
);
  localparam int IDX_W   = BUS_AW - PAGE_AW;
  localparam int ENTRIES = (1 << IDX_W) - 1;
  localparam int HIGH_W  = PHYS_AW - HALF_W;
  localparam logic [PHYS_AW-1:0] IO_BASE = {{(PHYS_AW-PAGE_AW){1'b1}}, {PAGE_AW{1'b0}}};
  localparam logic [IDX_W-1:0]   TOP_IDX = {IDX_W{1'b1}};

  logic [PHYS_AW-1:0] base_q [ENTRIES];

  logic [IDX_W-1:0]   page;
  logic               top_page;
  logic [PHYS_AW-1:0] zext, offset, sel_base, xlat;

  assign page     = req_addr[BUS_AW-1:PAGE_AW];
  assign top_page = (page == TOP_IDX);
  assign zext     = {{(PHYS_AW-BUS_AW){1'b0}}, req_addr};
  assign offset   = {{(PHYS_AW-PAGE_AW){1'b0}}, req_addr[PAGE_AW-1:0]};
  assign sel_base = top_page ? '0 : base_q[page];
  assign xlat     = top_page ? (zext | IO_BASE)
                  : map_en   ? (sel_base + offset)
                  : zext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) base_q[i] <= '0;
    end else if (wr_en && wr_idx != TOP_IDX) begin
      if (wr_hi)
        base_q[wr_idx][PHYS_AW-1:HALF_W] <= wr_data[HIGH_W-1:0];
      else
        base_q[wr_idx][HALF_W-1:0] <= {wr_data[HALF_W-1:1], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_addr <= xlat;
    end
  end
endmodule

module bus_relocator_chk #(
  parameter int BUS_AW  = 18,
  parameter int PHYS_AW = 22,
  parameter int PAGE_AW = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               map_en,
  input logic               req_valid,
  input logic [BUS_AW-1:0]  req_addr,
  input logic               rsp_valid,
  input logic [PHYS_AW-1:0] rsp_addr
);
  localparam logic [PHYS_AW-1:0] IO_BASE = {{(PHYS_AW-PAGE_AW){1'b1}}, {PAGE_AW{1'b0}}};
  logic top_req;
  logic [PHYS_AW-1:0] req_z;
  assign top_req = &req_addr[BUS_AW-1:PAGE_AW];
  assign req_z   = {{(PHYS_AW-BUS_AW){1'b0}}, req_addr};

  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_valid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_addr));
  assert_io_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && top_req) |=> rsp_addr == ($past(req_z) | IO_BASE));
  assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !top_req && !map_en) |=> rsp_addr == $past(req_z));
  assert_even_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_addr[0] == $past(req_addr[0]));
endmodule

bind bus_relocator bus_relocator_chk #(
  .BUS_AW(BUS_AW), .PHYS_AW(PHYS_AW), .PAGE_AW(PAGE_AW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .map_en(map_en), .req_valid(req_valid),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr)
);

// File: tb/bus_relocator_test.sv
`timescale 1ns/1ps
module bus_relocator_test;
  logic clk = 0, rst_n = 0, map_en = 0, wr_en = 0, wr_hi = 0, req_valid = 0;
  logic [4:0] wr_idx = 0;
  logic [15:0] wr_data = 0;
  logic [17:0] req_addr = 0;
  logic rsp_valid;
  logic [21:0] rsp_addr;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  bus_relocator uut (.clk(clk), .rst_n(rst_n), .map_en(map_en), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_data(wr_data), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr));

  // {map_en, req_addr, expected rsp_addr}
  localparam logic [40:0] VEC [12] = '{
    {1'b1, 18'h00000, 22'h031234},
    {1'b1, 18'h01FFF, 22'h033233},
    {1'b1, 18'h0A001, 22'h3FFFFF},
    {1'b1, 18'h0A002, 22'h000000},
    {1'b1, 18'h0BFFF, 22'h001FFD},
    {1'b1, 18'h3CABC, 22'h158ABC},
    {1'b1, 18'h02345, 22'h000345},
    {1'b0, 18'h0A123, 22'h00A123},
    {1'b0, 18'h3CABC, 22'h03CABC},
    {1'b1, 18'h3E000, 22'h3FE000},
    {1'b0, 18'h3FFFF, 22'h3FFFFF},
    {1'b1, 18'h3F555, 22'h3FF555}
  };

  task automatic chk(string req, logic [21:0] act, logic [21:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] idx, logic hi, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic xl(logic en, logic [17:0] a);
    @(negedge clk);
    map_en = en; req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid", {21'd0, rsp_valid}, 22'd0);
    chk("R1 rsp_addr", rsp_addr, 22'd0);
    rst_n = 1;
    xl(1, 18'h0A777);
    chk("R1 zero base", rsp_addr, 22'h000777);
    chk("R8 valid", {21'd0, rsp_valid}, 22'd1);

    wr(0, 0, 16'h1234); wr(0, 1, 16'h0003);
    wr(5, 0, 16'hFFFF); wr(5, 1, 16'hFF3F);
    wr(30, 0, 16'h8001); wr(30, 1, 16'h0015);

    for (int i = 0; i < 12; i++) begin
      xl(VEC[i][40], VEC[i][39:22]);
      chk("R2/R3/R4/R10 vector", rsp_addr, VEC[i][21:0]);
    end

    // R8: idle cycle holds address and drops valid
    @(negedge clk); req_addr = 18'h00000; map_en = 1;
    @(negedge clk);
    chk("R8 hold", rsp_addr, 22'h3FF555);
    chk("R8 idle valid", {21'd0, rsp_valid}, 22'd0);

    // R6: high half only
    wr(0, 1, 16'h0010);
    xl(1, 18'h00001);
    chk("R6 high half", rsp_addr, 22'h101235);

    // R5: low half only, bit 0 dropped
    wr(0, 0, 16'h0003);
    xl(1, 18'h00000);
    chk("R5 low half", rsp_addr, 22'h100002);

    // R7: index 31 write has no effect
    wr(31, 0, 16'hFFFF); wr(31, 1, 16'h003F);
    xl(1, 18'h3C000);
    chk("R7 page30", rsp_addr, 22'h158000);
    xl(1, 18'h00000);
    chk("R7 page0", rsp_addr, 22'h100002);
    xl(1, 18'h3E010);
    chk("R7 page31", rsp_addr, 22'h3FE010);

    // R9: same-cycle write uses old base
    @(negedge clk);
    wr_en = 1; wr_idx = 1; wr_hi = 0; wr_data = 16'h4000;
    map_en = 1; req_valid = 1; req_addr = 18'h02010;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    chk("R9 old base", rsp_addr, 22'h000010);
    xl(1, 18'h02010);
    chk("R9 new base", rsp_addr, 22'h004010);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule